// File: doc/BRIEF.md
# Timer Clock-Source Prescaler Front End

This block sits in front of a timer counter and turns a chosen stream of events into increment strobes. The events come either from the core's instruction-cycle enable or from an external clock pin. For the pin, the active edge is selectable. A power-of-two prescaler sits between the chosen event source and the strobe output. An 8-bit control register, written and read through a simple register port, holds all of these settings.

The same register also holds the polarity for a separate external interrupt pin. The block watches that pin and sets a sticky interrupt flag on the chosen edge. The flag stays set until an explicit clear is pulsed.

Both pins are asynchronous. Each passes through a synchronizer chain before edge detection. The downstream timer counter and the interrupt controller are not part of this block.

Top module: `tmr_prescale_front`

## Requirements
- R1: The register read port returns the last written value with bit 0 forced to 0. Bits 7..1 read back exactly as written, and the value reads back from the cycle after the write.
- R2: After reset, the register reads 0x00, and `inc_pulse`, `ext_edge_evt` and `irq_flag` are all 0. The zero register means: external source, falling clock edge, ratio 1:1, falling interrupt edge.
- R3: With bit 5 = 1, the source is internal, and every cycle with `cyc_en` high is one prescaler event. The external pin and bit 6 then have no effect on `inc_pulse`.
- R4: With bit 5 = 0, the source is the external pin. The pin passes through two synchronizing flops. Bit 6 = 1 counts rising edges and bit 6 = 0 counts falling edges; the other edge is ignored. At ratio 1:1, a pin change made between clock edges shows on `inc_pulse` just after the third following rising clock edge.
- R5: `ext_edge_evt` is a one-cycle pulse for each qualifying external clock edge. It has the same latency as `inc_pulse` at 1:1, and it fires only while the external source is selected.
- R6: Bits 4..1 form the prescale code. Codes 0..7 give one `inc_pulse` per 2^code events. Any code with bit 4 set gives one pulse per 256 events.
- R7: Any register write clears the prescaler count. After the write, a full new ratio of events is needed before the next `inc_pulse`.
- R8: Bit 7 = 1 makes a rising edge of `irq_pin` set `irq_flag`. Bit 7 = 0 makes a falling edge set it. The opposite edge does not set it. The flag goes high three rising clock edges after the pin change.
- R9: `irq_flag` stays high until `irq_clr` is asserted. If a clear and a qualifying edge meet in the same cycle, the flag stays set.
- R10: `inc_pulse` is one clock wide. At ratio 1:1, each event gives exactly one pulse. At ratios of 2 or more, two pulses are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data (bit 0 reads 0) |
| cyc_en | input | 1 | Instruction-cycle enable, internal event source |
| tclk_pin | input | 1 | Asynchronous external timer clock |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| irq_clr | input | 1 | Clears the interrupt flag |
| inc_pulse | output | 1 | One-cycle increment strobe to the timer |
| ext_edge_evt | output | 1 | One-cycle pulse per qualifying external clock edge |
| irq_flag | output | 1 | Sticky interrupt-pin flag |

## Verification
The assertions check four things on every cycle:
- write readback, and the clearing of the prescale count by a write;
- that internal-source strobes only follow an asserted `cyc_en`;
- that the external event pulse never appears under the internal source;
- that the interrupt flag holds until cleared, and that strobes are never adjacent at ratios above one.

The exact strobe counts per prescale code, including the 256 divide for every top-bit code, come only from the bench's scenarios. So do the three-edge latency through the synchronizers, edge polarity for both pins, and the set-over-clear collision.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

   typedef enum logic {
      SRC_PIN   = 1'b0,
      SRC_CYCLE = 1'b1
   } evt_src_e;

   // Number of counter bits that must wrap for one strobe.
   // Codes below half range give 2^code; the upper half saturates.
   function automatic int unsigned ratio_bits(input int unsigned code,
                                              input int unsigned code_w);
      int unsigned half;
      half = 1 << (code_w - 1);
      if (code >= half) return half;
      return code;
   endfunction

endpackage

// File: rtl/tpf_ctrl_reg.sv
module tpf_ctrl_reg
   import tpf_pkg::*;
#(
   parameter int unsigned PS_CODE_W = 4,
   localparam int unsigned REG_W    = PS_CODE_W + 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   output logic                 irq_rise_sel,
   output logic                 clk_rise_sel,
   output evt_src_e             src_sel,
   output logic [PS_CODE_W-1:0] ps_code
);

   localparam int unsigned POS_SRC  = PS_CODE_W + 1;
   localparam int unsigned POS_CEDG = PS_CODE_W + 2;
   localparam int unsigned POS_IEDG = PS_CODE_W + 3;

   logic [REG_W-1:1] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
      end else if (we) begin
         store_q <= wdata[REG_W-1:1];
      end
   end

   assign rdata        = {store_q, 1'b0};
   assign irq_rise_sel = store_q[POS_IEDG];
   assign clk_rise_sel = store_q[POS_CEDG];
   assign src_sel      = store_q[POS_SRC] ? SRC_CYCLE : SRC_PIN;
   assign ps_code      = store_q[PS_CODE_W:1];

endmodule

// File: rtl/tpf_edge_sync.sv
module tpf_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic edge_hit
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tpf_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // Chain: [0..STAGES-1] synchronizer, [STAGES] previous sample.
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-1:0], pin};
      end
   end

   logic now_s, prev_s;
   assign now_s  = chain_q[STAGES-1];
   assign prev_s = chain_q[STAGES];

   assign edge_hit = rise_sel ? (now_s & ~prev_s) : (~now_s & prev_s);

endmodule

// File: rtl/tpf_prescaler.sv
module tpf_prescaler
   import tpf_pkg::*;
#(
   parameter int unsigned PS_CODE_W = 4,
   localparam int unsigned CNT_W    = 1 << (PS_CODE_W - 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 evt,
   input  logic [PS_CODE_W-1:0] code,
   output logic                 strobe,
   output logic [CNT_W-1:0]     count
);

   logic [CNT_W-1:0] cnt_q;
   logic             strobe_q;
   logic [CNT_W:0]   one_sh;
   logic [CNT_W-1:0] wrap_mask;
   logic             at_wrap;

   always_comb begin
      one_sh    = (CNT_W+1)'(1) << ratio_bits(int'(code), PS_CODE_W);
      wrap_mask = CNT_W'(one_sh - (CNT_W+1)'(1));
      at_wrap   = ((cnt_q & wrap_mask) == wrap_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else if (clr) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= evt & at_wrap;
         if (evt) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign strobe = strobe_q;
   assign count  = cnt_q;

endmodule

// File: rtl/tmr_prescale_front.sv
module tmr_prescale_front
   import tpf_pkg::*;
#(
   parameter int unsigned PS_CODE_W   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned REG_W      = PS_CODE_W + 4,
   localparam int unsigned CNT_W      = 1 << (PS_CODE_W - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             cyc_en,
   input  logic             tclk_pin,
   input  logic             irq_pin,
   input  logic             irq_clr,
   output logic             inc_pulse,
   output logic             ext_edge_evt,
   output logic             irq_flag
);

   generate
      if (PS_CODE_W < 2 || PS_CODE_W > 5) begin : g_bad_code_w
         $error("tmr_prescale_front: PS_CODE_W must be within 2..5");
      end
   endgenerate

   logic                 irq_rise_sel, clk_rise_sel;
   evt_src_e             src_sel;
   logic [PS_CODE_W-1:0] ps_code;
   logic                 clk_hit, irq_hit, sel_evt;
   logic [CNT_W-1:0]     pre_cnt;
   logic                 ext_evt_q, irq_q;

   tpf_ctrl_reg #(.PS_CODE_W(PS_CODE_W)) u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (reg_we),
      .wdata        (reg_wdata),
      .rdata        (reg_rdata),
      .irq_rise_sel (irq_rise_sel),
      .clk_rise_sel (clk_rise_sel),
      .src_sel      (src_sel),
      .ps_code      (ps_code)
   );

   tpf_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (tclk_pin),
      .rise_sel (clk_rise_sel),
      .edge_hit (clk_hit)
   );

   tpf_edge_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (irq_pin),
      .rise_sel (irq_rise_sel),
      .edge_hit (irq_hit)
   );

   assign sel_evt = (src_sel == SRC_CYCLE) ? cyc_en : clk_hit;

   tpf_prescaler #(.PS_CODE_W(PS_CODE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (reg_we),
      .evt    (sel_evt),
      .code   (ps_code),
      .strobe (inc_pulse),
      .count  (pre_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_evt_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         ext_evt_q <= (src_sel == SRC_PIN) & clk_hit;
         if (irq_hit)      irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
      end
   end

   assign ext_edge_evt = ext_evt_q;
   assign irq_flag     = irq_q;

endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
   parameter int unsigned PS_CODE_W = 4,
   localparam int unsigned REG_W    = PS_CODE_W + 4,
   localparam int unsigned CNT_W    = 1 << (PS_CODE_W - 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             cyc_en,
   input logic             irq_clr,
   input logic             inc_pulse,
   input logic             ext_edge_evt,
   input logic             irq_flag,
   input logic [CNT_W-1:0] pre_cnt
);

   localparam int unsigned POS_SRC = PS_CODE_W + 1;

   // R1: written value readable next cycle, bit 0 zero
   a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we) |-> reg_rdata == ($past(reg_wdata) & ~REG_W'(1)));

   // R7: a write leaves the prescaler empty and no strobe pending
   a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we) |-> (pre_cnt == '0 && !inc_pulse));

   // R3: internal-source strobe follows an enabled cycle
   a_r3_cycle_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_pulse && reg_rdata[POS_SRC] && $past(reg_rdata[POS_SRC]))
         |-> $past(cyc_en));

   // R5: external event pulse only under external source
   a_r5_evt_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
      ext_edge_evt |-> !$past(reg_rdata[POS_SRC]));

   // R9: flag holds without a clear
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   // R10: ratios above one never give adjacent strobes
   a_r10_ratio_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_pulse && reg_rdata[PS_CODE_W:1] != '0) |=> !inc_pulse);

endmodule

bind tmr_prescale_front tpf_checker #(.PS_CODE_W(PS_CODE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .cyc_en       (cyc_en),
   .irq_clr      (irq_clr),
   .inc_pulse    (inc_pulse),
   .ext_edge_evt (ext_edge_evt),
   .irq_flag     (irq_flag),
   .pre_cnt      (pre_cnt)
);

// File: tb/tmr_prescale_front_test.sv
`timescale 1ns/1ps
module tmr_prescale_front_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       cyc_en = 1'b0;
   logic       tclk_pin = 1'b0;
   logic       irq_pin = 1'b0;
   logic       irq_clr = 1'b0;
   logic       inc_pulse, ext_edge_evt, irq_flag;

   int nchk = 0;
   int nfail = 0;
   int pcnt = 0;
   int ecnt = 0;

   always #4 clk = ~clk;

   tmr_prescale_front uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_we       (reg_we),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .cyc_en       (cyc_en),
      .tclk_pin     (tclk_pin),
      .irq_pin      (irq_pin),
      .irq_clr      (irq_clr),
      .inc_pulse    (inc_pulse),
      .ext_edge_evt (ext_edge_evt),
      .irq_flag     (irq_flag)
   );

   // Pulse counters, sampling the value held before each edge
   always @(posedge clk) begin
      if (inc_pulse)    pcnt <= pcnt + 1;
      if (ext_edge_evt) ecnt <= ecnt + 1;
   end

   // Table: {control value, event count, expected strobes}, internal source
   localparam logic [31:0] TBL [10] = '{
      {8'h20, 12'd5,   12'd5},   // R6 code 0 -> 1:1
      {8'h22, 12'd5,   12'd2},   // R6 code 1 -> 1:2
      {8'h24, 12'd9,   12'd2},   // R6 code 2 -> 1:4
      {8'h26, 12'd16,  12'd2},   // R6 code 3 -> 1:8
      {8'h28, 12'd47,  12'd2},   // R6 code 4 -> 1:16
      {8'h2E, 12'd255, 12'd1},   // R6 code 7 -> 1:128
      {8'h2E, 12'd256, 12'd2},   // R6 code 7 -> 1:128
      {8'h30, 12'd255, 12'd0},   // R6 code 8 -> 1:256
      {8'h30, 12'd256, 12'd1},   // R6 code 8 -> 1:256
      {8'h3E, 12'd256, 12'd1}    // R6 code 15 -> 1:256
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cyc_burst(input int n);
      for (int i = 0; i < n; i++) begin
         cyc_en = 1'b1;
         @(negedge clk);
      end
      cyc_en = 1'b0;
   endtask

   task automatic pin_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         tclk_pin = 1'b1; idle(4);
         tclk_pin = 1'b0; idle(4);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog expired actual=running expected=done");
      nchk++;
      nfail++;
      summary();
      $finish;
   end

   initial begin
      idle(3);
      // R2: reset state
      chk("R2 rdata", reg_rdata, 8'h00);
      chk("R2 inc", inc_pulse, 1'b0);
      chk("R2 irq", irq_flag, 1'b0);
      rst_n = 1'b1;
      idle(3);
      chk("R2 rdata after release", reg_rdata, 8'h00);
      chk("R2 evt", ext_edge_evt, 1'b0);

      // R6 table walk
      for (int k = 0; k < 10; k++) begin
         wr(TBL[k][31:24]);
         pcnt = 0;
         cyc_burst(int'(TBL[k][23:12]));
         idle(4);
         chk($sformatf("R6 row %0d", k), pcnt, TBL[k][11:0]);
      end

      // R1: readback with bit 0 forced low
      wr(8'hFF);
      chk("R1 readback FF", reg_rdata, 8'hFE);
      wr(8'hA5);
      chk("R1 readback A5", reg_rdata, 8'hA4);

      // R4: external falling edge, rising ignored, latency
      wr(8'h00);
      idle(2);
      pcnt = 0; ecnt = 0;
      tclk_pin = 1'b1;
      idle(5);
      chk("R4 rising ignored when falling selected", pcnt, 0);
      tclk_pin = 1'b0;
      idle(2);
      chk("R4 no strobe before third edge", inc_pulse, 1'b0);
      idle(1);
      chk("R4 strobe at third edge", inc_pulse, 1'b1);
      chk("R5 event at third edge", ext_edge_evt, 1'b1);
      idle(1);
      chk("R10 strobe one cycle wide", inc_pulse, 1'b0);
      idle(3);
      chk("R10 one strobe per event", pcnt, 1);

      // R4: rising edges, R5 event count
      wr(8'h40);
      pcnt = 0; ecnt = 0;
      pin_pulse(3);
      chk("R4 rising edge count", pcnt, 3);
      chk("R5 event count", ecnt, 3);

      // R6 on external source: 1:4
      wr(8'h44);
      pcnt = 0;
      pin_pulse(8);
      chk("R6 external 1:4", pcnt, 2);

      // R3: internal source ignores pin and edge bit
      wr(8'h60);
      pcnt = 0; ecnt = 0;
      pin_pulse(3);
      chk("R3 pin ignored under internal source", pcnt, 0);
      chk("R5 no event under internal source", ecnt, 0);
      cyc_burst(3);
      idle(3);
      chk("R3 cycle events counted", pcnt, 3);

      // R7: write restarts the ratio
      wr(8'h22);
      pcnt = 0;
      cyc_burst(1);
      wr(8'h22);
      cyc_burst(1);
      idle(3);
      chk("R7 count cleared by write", pcnt, 0);
      cyc_burst(1);
      idle(3);
      chk("R7 strobe after full ratio", pcnt, 1);

      // R8: falling interrupt edge
      wr(8'h00);
      irq_pin = 1'b1;
      idle(5);
      chk("R8 rising ignored when falling selected", irq_flag, 1'b0);
      irq_pin = 1'b0;
      idle(2);
      chk("R8 flag not yet set", irq_flag, 1'b0);
      idle(1);
      chk("R8 flag set at third edge", irq_flag, 1'b1);
      idle(5);
      chk("R9 flag holds", irq_flag, 1'b1);
      irq_clr = 1'b1; idle(1); irq_clr = 1'b0;
      chk("R9 flag cleared", irq_flag, 1'b0);

      // R8: rising interrupt edge
      wr(8'h80);
      irq_pin = 1'b1;
      idle(5);
      chk("R8 rising sets flag", irq_flag, 1'b1);

      // R9: set wins over clear
      irq_pin = 1'b0;
      idle(5);
      chk("R9 falling ignored, flag held", irq_flag, 1'b1);
      irq_pin = 1'b1;
      idle(2);
      irq_clr = 1'b1;
      idle(1);
      irq_clr = 1'b0;
      chk("R9 set wins over clear", irq_flag, 1'b1);
      irq_clr = 1'b1; idle(1); irq_clr = 1'b0;
      chk("R9 clear after collision", irq_flag, 1'b0);

      idle(2);
      summary();
      $finish;
   end

endmodule